// File: doc/BRIEF.md
# Frequency-Locked Loop Lock Controller

This block is the digital half of a frequency-locked loop. It runs on the output clock of a digitally controlled oscillator and counts output cycles between two rising edges of a reference. It compares each count with a programmed multiplication factor and nudges a coarse code and a fine code, which steer the oscillator, toward the target. The oscillator itself sits outside the block.

There are two reference sources. In normal operation the reference is an ordinary slow clock. The lock sequence runs a coarse search, then a fine search, then fine tracking. The coarse search can be skipped so that the loop starts from a programmed coarse code. In clock recovery mode the reference is the 1 ms start-of-frame pulse train from a USB device. With a factor of 0xBB80 (48000), that gives a 48 MHz output. In this mode the coarse code comes straight from its initial value, and the loop goes directly to fine search. After lock, a sign-agreement filter takes the place of the optional fine-code freeze.

A configuration bit decides what a disable does. With the bit clear, the block keeps its codes and lock flags and resumes tracking when it is enabled again. With the bit set, the block drops the locks and runs the whole lock sequence again.

Top module: `fll_lock_ctrl`

## Requirements
- R1: After reset, `coarse_code` equals `coarse_init`, `fine_code` equals `fine_init`, and both lock flags are 0.
- R2: Each accepted measurement is a cycle count. If the count is greater than `mult_factor`, a fine adjustment lowers `fine_code` by 1. If it is smaller, the adjustment raises `fine_code` by 1. If it is equal, nothing changes. The code saturates at 0 and at its all-ones value, and it never changes between measurements.
- R3: In normal mode with the coarse search enabled, each measurement whose error exceeds `CRS_TOL` moves `coarse_code` by 1 (down when the count is high, up when it is low). The first measurement with |error| <= `CRS_TOL` sets `coarse_locked` and starts the fine search.
- R4: With `bypass_coarse` set in normal mode, `coarse_locked` rises within two cycles of enable. `coarse_code` then stays at `coarse_init` while the loop searches and tracks.
- R5: During the fine search, `fine_locked` rises after two consecutive measurements with |error| <= `lock_tol`. A measurement outside the tolerance restarts that count. `fine_locked` never stands without `coarse_locked`.
- R6: In normal mode after fine lock, `freeze_fine` = 1 holds `fine_code`. With `freeze_fine` = 0, tracking continues as in R2.
- R7: Clock recovery mode applies only when both `recovery_en` and `closed_loop` are 1. In that mode `sof_pulse` is the reference and `ref_clk` is ignored. `bypass_coarse` is ignored, `coarse_init` is used as the final coarse code, and `coarse_locked` is set at start.
- R8: In recovery mode after fine lock, `freeze_fine` is ignored. `fine_code` moves only when the current error and the previous error are nonzero and of the same sign.
- R9: If `lose_lock_on_wake` is 0 when `enable` falls, the codes and lock flags are kept through the disable. Reference edges seen while the block is disabled have no effect, and tracking resumes after re-enable.
- R10: If `lose_lock_on_wake` is 1 on the cycle where `enable` falls, both lock flags clear and the codes reload from their initial values. Changing the bit later, while the block is disabled, has no effect.
- R11: An interval longer than 2 x `mult_factor` cycles is discarded and leaves the codes unchanged. An interval of exactly 2 x `mult_factor` is accepted. The edge that ends a discarded interval starts the next one.
- R12: With `closed_loop` = 0, the codes follow `coarse_init` and `fine_init`, no lock flag is set, and reference edges are ignored.
- R13: The first reference edge after enable only starts a measurement. It changes no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator output clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Loop enable |
| closed_loop | input | 1 | 1 = closed-loop operation, 0 = codes follow initial values |
| recovery_en | input | 1 | Clock recovery mode request |
| bypass_coarse | input | 1 | Skip the coarse search in normal mode |
| freeze_fine | input | 1 | Hold the fine code after lock in normal mode |
| lose_lock_on_wake | input | 1 | 1 = drop locks on disable |
| ref_clk | input | 1 | Normal reference clock (asynchronous) |
| sof_pulse | input | 1 | USB start-of-frame pulse (asynchronous) |
| mult_factor | input | MULT_W | Target output cycles per reference period |
| lock_tol | input | TOL_W | Fine lock tolerance in cycles |
| coarse_init | input | COARSE_W | Initial coarse code (final coarse code in recovery and bypass) |
| fine_init | input | FINE_W | Initial fine code |
| coarse_code | output | COARSE_W | Coarse oscillator code |
| fine_code | output | FINE_W | Fine oscillator code |
| coarse_locked | output | 1 | Coarse lock flag |
| fine_locked | output | 1 | Fine lock flag |

## Verification
The assertions assume that `mult_factor`, `lock_tol` and the mode bits stay constant while the loop runs. They also assume that each reference high phase lasts at least two output clock cycles, so that the synchroniser catches every edge. The bench changes configuration only while the loop is disabled or between reference edges. It holds every reference pulse high for two cycles and spaces the edges at least six cycles apart. It stands in for the oscillator by choosing each interval length directly, which lets it set every error value.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COARSE,
        ST_FINE,
        ST_TRACK
    } lock_state_e;

    typedef enum logic [1:0] {
        SG_ZERO,
        SG_POS,
        SG_NEG
    } err_sign_e;

    typedef struct packed {
        logic coarse;
        logic fine;
    } lock_flags_t;

    localparam int NUM_REF = 2;
    localparam int REF_NORMAL = 0;
    localparam int REF_SOF = 1;

    function automatic err_sign_e sign_of(input logic is_neg, input logic is_zero);
        if (is_zero) return SG_ZERO;
        return is_neg ? SG_NEG : SG_POS;
    endfunction

endpackage

// File: rtl/fll_ref_edge.sv
module fll_ref_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [1:0] sync_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], async_in};
            prev_q <= sync_q[1];
        end
    end

    assign rise_o = sync_q[1] & ~prev_q;

endmodule

// File: rtl/fll_period_ctr.sv
module fll_period_ctr #(
    parameter int MULT_W = 16,
    localparam int CNT_W = MULT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              ev,
    input  logic [MULT_W-1:0] mult,
    output logic              meas_valid,
    output logic [CNT_W-1:0]  meas_count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
    logic             armed_q;

    assign limit   = {1'b0, mult, 1'b0};
    assign cnt_inc = cnt_q + ONE;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q      <= '0;
            armed_q    <= 1'b0;
            meas_valid <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= 1'b0;
            if (ev) begin
                meas_valid <= armed_q;
                meas_count <= cnt_inc;
                cnt_q      <= '0;
                armed_q    <= 1'b1;
            end else begin
                if (cnt_q != '1) cnt_q <= cnt_inc;
                if (cnt_inc >= limit) armed_q <= 1'b0;
            end
        end
    end

    // R11
    count_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> (meas_count <= limit));

endmodule

// File: rtl/fll_code_loop.sv
module fll_code_loop
    import fll_pkg::*;
#(
    parameter int MULT_W   = 16,
    parameter int COARSE_W = 6,
    parameter int FINE_W   = 10,
    parameter int TOL_W    = 4,
    parameter int CRS_TOL  = 64,
    localparam int CNT_W   = MULT_W + 2,
    localparam int ERR_W   = CNT_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                recovery,
    input  logic                bypass,
    input  logic                freeze,
    input  logic                lose_lock,
    input  logic                meas_valid,
    input  logic [CNT_W-1:0]    meas_count,
    input  logic [MULT_W-1:0]   mult,
    input  logic [TOL_W-1:0]    tolerance,
    input  logic [COARSE_W-1:0] coarse_init,
    input  logic [FINE_W-1:0]   fine_init,
    output logic [COARSE_W-1:0] coarse_q,
    output logic [FINE_W-1:0]   fine_q,
    output lock_flags_t         flags_q
);
    localparam logic [COARSE_W-1:0] C_MAX = '1;
    localparam logic [FINE_W-1:0]   F_MAX = '1;
    localparam logic [ERR_W-1:0]    CRS_LIM = ERR_W'(CRS_TOL);

    lock_state_e        state_q;
    err_sign_e          sg, prev_q;
    logic               run_q, streak_q, drop;
    logic signed [ERR_W-1:0] err;
    logic [ERR_W-1:0]   abs_err;
    logic               in_tol, coarse_ok;
    logic [FINE_W-1:0]  fine_step;
    logic [COARSE_W-1:0] coarse_step;

    assign err       = $signed({1'b0, meas_count}) - $signed({{(ERR_W-MULT_W){1'b0}}, mult});
    assign abs_err   = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    assign sg        = sign_of(err[ERR_W-1], err == '0);
    assign in_tol    = abs_err <= {{(ERR_W-TOL_W){1'b0}}, tolerance};
    assign coarse_ok = abs_err <= CRS_LIM;
    assign drop      = run_q && !run && lose_lock;

    always_comb begin
        fine_step   = fine_q;
        coarse_step = coarse_q;
        if (sg == SG_POS) begin
            if (fine_q != '0)   fine_step   = fine_q - 1'b1;
            if (coarse_q != '0) coarse_step = coarse_q - 1'b1;
        end else if (sg == SG_NEG) begin
            if (fine_q != F_MAX)   fine_step   = fine_q + 1'b1;
            if (coarse_q != C_MAX) coarse_step = coarse_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            coarse_q <= coarse_init;
            fine_q   <= fine_init;
            flags_q  <= '0;
            streak_q <= 1'b0;
            prev_q   <= SG_ZERO;
            run_q    <= 1'b0;
        end else begin
            run_q <= run;
            if (drop) begin
                state_q  <= ST_IDLE;
                flags_q  <= '0;
                streak_q <= 1'b0;
                prev_q   <= SG_ZERO;
            end else if (!run) begin
                if (state_q == ST_IDLE) begin
                    coarse_q <= coarse_init;
                    fine_q   <= fine_init;
                end
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        coarse_q <= coarse_init;
                        fine_q   <= fine_init;
                        streak_q <= 1'b0;
                        prev_q   <= SG_ZERO;
                        if (recovery || bypass) begin
                            flags_q.coarse <= 1'b1;
                            state_q        <= ST_FINE;
                        end else begin
                            state_q <= ST_COARSE;
                        end
                    end
                    ST_COARSE: if (meas_valid) begin
                        if (coarse_ok) begin
                            flags_q.coarse <= 1'b1;
                            state_q        <= ST_FINE;
                        end else begin
                            coarse_q <= coarse_step;
                        end
                    end
                    ST_FINE: if (meas_valid) begin
                        fine_q <= fine_step;
                        prev_q <= sg;
                        if (!in_tol) begin
                            streak_q <= 1'b0;
                        end else if (streak_q) begin
                            flags_q.fine <= 1'b1;
                            state_q      <= ST_TRACK;
                        end else begin
                            streak_q <= 1'b1;
                        end
                    end
                    default: if (meas_valid) begin
                        prev_q <= sg;
                        if (recovery) begin
                            if (sg != SG_ZERO && sg == prev_q) fine_q <= fine_step;
                        end else if (!freeze) begin
                            fine_q <= fine_step;
                        end
                    end
                endcase
            end
        end
    end

    // R2
    fine_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (run && state_q != ST_IDLE && !meas_valid) |=> $stable(fine_q));

    // R2
    fine_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && state_q != ST_IDLE) |=>
            (fine_q == $past(fine_q) || fine_q == $past(fine_q) + 1'b1 ||
             fine_q == $past(fine_q) - 1'b1));

    // R5
    lock_order_chk: assert property (@(posedge clk) disable iff (rst)
        flags_q.fine |-> flags_q.coarse);

    // R4
    coarse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FINE || state_q == ST_TRACK) |=> $stable(coarse_q));

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRACK && !recovery && freeze) |=> $stable(fine_q));

    // R10
    wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(run) && lose_lock) |=> (flags_q == '0));

endmodule

// File: rtl/fll_lock_ctrl.sv
module fll_lock_ctrl
    import fll_pkg::*;
#(
    parameter int MULT_W   = 16,
    parameter int COARSE_W = 6,
    parameter int FINE_W   = 10,
    parameter int TOL_W    = 4,
    parameter int CRS_TOL  = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                closed_loop,
    input  logic                recovery_en,
    input  logic                bypass_coarse,
    input  logic                freeze_fine,
    input  logic                lose_lock_on_wake,
    input  logic                ref_clk,
    input  logic                sof_pulse,
    input  logic [MULT_W-1:0]   mult_factor,
    input  logic [TOL_W-1:0]    lock_tol,
    input  logic [COARSE_W-1:0] coarse_init,
    input  logic [FINE_W-1:0]   fine_init,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code,
    output logic                coarse_locked,
    output logic                fine_locked
);
    localparam int CNT_W = MULT_W + 2;

    logic [NUM_REF-1:0] ref_raw, ref_rise;
    logic               run, recovery, ev, meas_valid;
    logic [CNT_W-1:0]   meas_count;
    lock_flags_t        flags;

    assign run      = enable & closed_loop;
    assign recovery = recovery_en & closed_loop;
    assign ref_raw[REF_NORMAL] = ref_clk;
    assign ref_raw[REF_SOF]    = sof_pulse;

    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
        fll_ref_edge u_edge (
            .clk      (clk),
            .rst      (rst),
            .async_in (ref_raw[i]),
            .rise_o   (ref_rise[i])
        );
    end

    assign ev = recovery ? ref_rise[REF_SOF] : ref_rise[REF_NORMAL];

    fll_period_ctr #(.MULT_W(MULT_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .clear      (!run),
        .ev         (ev),
        .mult       (mult_factor),
        .meas_valid (meas_valid),
        .meas_count (meas_count)
    );

    fll_code_loop #(
        .MULT_W   (MULT_W),
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .TOL_W    (TOL_W),
        .CRS_TOL  (CRS_TOL)
    ) u_loop (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .recovery    (recovery),
        .bypass      (bypass_coarse),
        .freeze      (freeze_fine),
        .lose_lock   (lose_lock_on_wake),
        .meas_valid  (meas_valid),
        .meas_count  (meas_count),
        .mult        (mult_factor),
        .tolerance   (lock_tol),
        .coarse_init (coarse_init),
        .fine_init   (fine_init),
        .coarse_q    (coarse_code),
        .fine_q      (fine_code),
        .flags_q     (flags)
    );

    assign coarse_locked = flags.coarse;
    assign fine_locked   = flags.fine;

    // R12
    open_loop_chk: assert property (@(posedge clk) disable iff (rst)
        !closed_loop |=> !$rose(coarse_locked) && !$rose(fine_locked));

endmodule

// File: tb/fll_lock_ctrl_bench.sv
module fll_lock_ctrl_bench;
    localparam int MULT = 40;
    localparam int CTOL = 4;
    localparam int FMAX = 31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 0, closed_loop = 0, recovery_en = 0, bypass_coarse = 0;
    logic       freeze_fine = 0, lose_lock_on_wake = 1, ref_clk = 0, sof_pulse = 0;
    logic [7:0] mult_factor = 8'(MULT);
    logic [1:0] lock_tol = 2'd1;
    logic [3:0] coarse_init = 4'd8;
    logic [4:0] fine_init = 5'd16;
    logic [3:0] coarse_code;
    logic [4:0] fine_code;
    logic       coarse_locked, fine_locked;

    int  n_run = 0, n_fail = 0;
    bit  use_sof = 0;
    int  exp_c, exp_f, streak;

    always #10 clk = ~clk;

    fll_lock_ctrl #(
        .MULT_W(8), .COARSE_W(4), .FINE_W(5), .TOL_W(2), .CRS_TOL(CTOL)
    ) u_fll_lock_ctrl (
        .clk(clk), .rst(rst), .enable(enable), .closed_loop(closed_loop),
        .recovery_en(recovery_en), .bypass_coarse(bypass_coarse),
        .freeze_fine(freeze_fine), .lose_lock_on_wake(lose_lock_on_wake),
        .ref_clk(ref_clk), .sof_pulse(sof_pulse), .mult_factor(mult_factor),
        .lock_tol(lock_tol), .coarse_init(coarse_init), .fine_init(fine_init),
        .coarse_code(coarse_code), .fine_code(fine_code),
        .coarse_locked(coarse_locked), .fine_locked(fine_locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ref(input logic v);
        if (use_sof) sof_pulse = v; else ref_clk = v;
    endtask

    // rising edge, two cycles high, then two settle cycles
    task automatic edge_tail();
        @(negedge clk) set_ref(1'b1);
        @(negedge clk);
        @(negedge clk) set_ref(1'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic first_rise();
        edge_tail();
    endtask

    // next rising edge lands p cycles after the previous one
    task automatic interval(input int p);
        repeat (p - 5) @(negedge clk);
        edge_tail();
    endtask

    function automatic int fstep(input int f, input int e);
        if (e > 0) return (f > 0) ? f - 1 : 0;
        if (e < 0) return (f < FMAX) ? f + 1 : FMAX;
        return f;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cp[5] = '{50, 47, 30, 35, 36};
        int fp[5] = '{43, 41, 38, 40, 39};
        int rp[6] = '{45, 45, 35, 35, 40, 40};
        bit same;
        int prev_e;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 coarse", coarse_code, 8);
        check("R1 fine", fine_code, 16);
        check("R1 locks", {coarse_locked, fine_locked}, 0);

        // R12 and R7: open loop, recovery request alone has no effect
        enable = 1; recovery_en = 1; coarse_init = 4'd5;
        repeat (2) @(negedge clk);
        check("R12 coarse follows init", coarse_code, 5);
        for (int s = 0; s < 2; s++) begin
            use_sof = s[0];
            first_rise(); interval(50); interval(30);
            check("R12 coarse", coarse_code, 5);
            check("R7 needs closed loop", fine_code, 16);
            check("R12 locks", {coarse_locked, fine_locked}, 0);
        end
        use_sof = 0; recovery_en = 0; coarse_init = 4'd8;
        repeat (2) @(negedge clk);

        // R13 and R3
        closed_loop = 1;
        first_rise();
        check("R13 first edge", coarse_code, 8);
        exp_c = 8;
        foreach (cp[i]) begin
            interval(cp[i]);
            if (cp[i] - MULT > CTOL) exp_c--;
            else if (MULT - cp[i] > CTOL) exp_c++;
            check("R3 coarse", coarse_code, exp_c);
            check("R3 coarse lock", coarse_locked, (i == 4) ? 1 : 0);
        end

        // R5 fine search with tolerance 1
        exp_f = 16; streak = 0;
        foreach (fp[i]) begin
            interval(fp[i]);
            exp_f = fstep(exp_f, fp[i] - MULT);
            streak = ((fp[i] - MULT) <= 1 && (MULT - fp[i]) <= 1) ? streak + 1 : 0;
            check("R5 fine", fine_code, exp_f);
            check("R5 fine lock", fine_locked, (streak >= 2) ? 1 : 0);
        end

        // R6
        interval(45); exp_f = fstep(exp_f, 5);
        check("R6 tracking", fine_code, exp_f);
        freeze_fine = 1;
        interval(45); check("R6 frozen", fine_code, exp_f);
        interval(30); check("R6 frozen", fine_code, exp_f);
        freeze_fine = 0;

        // R2 sweeps to both limits
        for (int i = 0; i < 20; i++) begin
            interval(30); exp_f = fstep(exp_f, -10);
            check("R2 up", fine_code, exp_f);
        end
        for (int i = 0; i < 35; i++) begin
            interval(50); exp_f = fstep(exp_f, 10);
            check("R2 down", fine_code, exp_f);
        end
        for (int i = 0; i < 3; i++) interval(30);
        exp_f = 3;
        check("R2 resume", fine_code, exp_f);

        // R11
        interval(81); check("R11 long interval", fine_code, exp_f);
        interval(80); exp_f--; check("R11 limit interval", fine_code, exp_f);

        // R9
        lose_lock_on_wake = 0;
        @(negedge clk) enable = 0;
        first_rise(); interval(30); interval(30);
        check("R9 coarse", coarse_code, 8);
        check("R9 fine", fine_code, exp_f);
        check("R9 locks", {coarse_locked, fine_locked}, 3);
        enable = 1;
        first_rise(); interval(50); exp_f--;
        check("R9 resumed", fine_code, exp_f);
        check("R9 lock kept", fine_locked, 1);

        // R10
        lose_lock_on_wake = 1;
        @(negedge clk) enable = 0;
        @(negedge clk) lose_lock_on_wake = 0;
        repeat (3) @(negedge clk);
        check("R10 locks", {coarse_locked, fine_locked}, 0);
        check("R10 coarse", coarse_code, 8);
        check("R10 fine", fine_code, 16);

        // R4
        bypass_coarse = 1; enable = 1;
        repeat (2) @(negedge clk);
        check("R4 coarse lock", coarse_locked, 1);
        check("R4 fine lock", fine_locked, 0);
        first_rise(); interval(40);
        check("R4 one in tol", fine_locked, 0);
        interval(40);
        check("R4 two in tol", fine_locked, 1);
        interval(60);
        check("R4 coarse held", coarse_code, 8);
        check("R4 fine tracks", fine_code, 15);

        // R7 recovery
        lose_lock_on_wake = 1;
        @(negedge clk) enable = 0;
        repeat (2) @(negedge clk);
        recovery_en = 1; bypass_coarse = 0; freeze_fine = 1; coarse_init = 4'd3;
        enable = 1;
        repeat (2) @(negedge clk);
        check("R7 coarse init", coarse_code, 3);
        check("R7 coarse lock", coarse_locked, 1);
        use_sof = 0;
        first_rise(); interval(50); interval(50);
        check("R7 ref ignored", fine_code, 16);
        use_sof = 1;
        first_rise(); interval(40); interval(40);
        check("R7 fine lock", fine_locked, 1);

        // R8 sign agreement filter, freeze ignored
        exp_f = 16; prev_e = 0;
        foreach (rp[i]) begin
            interval(rp[i]);
            same = (rp[i] - MULT > 0 && prev_e > 0) || (rp[i] - MULT < 0 && prev_e < 0);
            if (same) exp_f = fstep(exp_f, rp[i] - MULT);
            prev_e = rp[i] - MULT;
            check("R8 filtered fine", fine_code, exp_f);
        end
        check("R7 coarse final", coarse_code, 3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule